// File: doc/BRIEF.md
# Filtered Pin Edge Interrupt Unit

This block turns the input levels of a port of general-purpose pins into interrupt flags and event strobes. Each asynchronous pin is first brought into the clock domain by a synchronizer. It may then pass through a per-pin glitch filter, and it ends in an edge detector that can be set per pin to fire on any change, on a rising edge only or on a falling edge only. A detected edge sets a sticky per-pin flag. The flags, masked by per-pin enables, are ORed into one interrupt request line.

A second edge detector on each pin drives a one-cycle event strobe that other on-chip blocks can use as a trigger. For each pin, software chooses whether this strobe comes from the filtered signal or from the plain synchronized signal. All configuration sits behind a small register bus. Writes use the low two address bits to select plain write, bit set, bit clear or bit toggle, so one pin can be changed without a read-modify-write.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, every configuration register reads zero, every flag is clear, `irq_req` is low and `evt_pulse` is zero.
- R2: A write selects a register with address bits [4:2] and an operation with bits [1:0]. The registers are 0 filter enable, 1 mode low bit, 2 mode high bit, 3 interrupt enable, 4 event-uses-filter select, 5 flags and 6 synchronized pin level (read-only). The operations are 00 write the value, 01 set the ones, 10 clear the ones and 11 toggle the ones. A read returns the selected register whatever the operation bits are, and a write to register 6 has no effect.
- R3: The edge mode of a pin is {mode high bit, mode low bit}: 00 any change, 01 rising only, 10 falling only, 11 any change.
- R4: A flag stays set until a one is written to its bit with the clear operation on register 5. This works while the pin's interrupt is enabled. The write, set and toggle operations on register 5 do not change the flags.
- R5: If a clear of a flag arrives in the same cycle as a new edge on that pin, the flag stays set.
- R6: `irq_req` is high exactly when some pin has both its flag and its interrupt enable set. Flags are set whether or not the enable is set.
- R7: When a pin's interrupt enable changes from 0 to 1 through any operation, its filter enable is set in the same cycle. The filter enable can still be cleared afterwards on its own.
- R8: With the filter on, an input pulse one clock long never sets a flag, and a pulse two clocks long always does.
- R9: With the default two-stage synchronizer, an unfiltered edge sets its flag at the third rising clock edge after the input changes. The filter adds exactly two cycles.
- R10: `evt_pulse` is high for one cycle per detected edge, in the pin's edge mode. It does not depend on the flags or enables. With select bit 0 it comes two clocks after the input change, and with select bit 1 it comes through the filter, two clocks later.
- R11: Turning a pin's filter on or off while its input is steady does not create an edge or set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register index [4:2] and operation [1:0] |
| bus_wdata | input | NPINS | Write data / bit mask |
| bus_rdata | output | NPINS | Read data of the addressed register |
| irq_req | output | 1 | Masked port interrupt request |
| evt_pulse | output | NPINS | One-cycle per-pin event strobes |

## Verification
The bench drives pulses of exactly one and two clocks through the filter. A filter whose agreement window is off by one would either let the short pulse set a flag or lose the long one. It lines up a flag clear with the cycle in which a fresh edge is being detected. A design where the clear wins there loses an interrupt. It samples flags and strobes one cycle before and at their expected arrival, which catches an extra or missing pipeline stage in either path. It also checks that enabling an interrupt sets the filter bit, and that switching the filter on a steady pin sets no flag. A design that rebuilt the filter state on enable would produce a false edge at that point.

// File: rtl/pei_pkg.sv
package pei_pkg;

  localparam int unsigned REG_IDX_W  = 3;
  localparam int unsigned BUS_ADDR_W = REG_IDX_W + 2;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } alias_op_e;

  localparam logic [REG_IDX_W-1:0] REG_FILT  = 3'd0;
  localparam logic [REG_IDX_W-1:0] REG_MLO   = 3'd1;
  localparam logic [REG_IDX_W-1:0] REG_MHI   = 3'd2;
  localparam logic [REG_IDX_W-1:0] REG_IEN   = 3'd3;
  localparam logic [REG_IDX_W-1:0] REG_EVSEL = 3'd4;
  localparam logic [REG_IDX_W-1:0] REG_FLAG  = 3'd5;
  localparam logic [REG_IDX_W-1:0] REG_LEVEL = 3'd6;

endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] st_d;
    if (s == 0) begin : g_first
      assign st_d = din;
    end else begin : g_next
      assign st_d = st_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= '0;
      else        st_q[s] <= st_d;
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/pei_alias_reg.sv
module pei_alias_reg
  import pei_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] force_set,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, d;

  always_comb begin
    d = q_r;
    if (wr_en) begin
      unique case (op)
        OP_WRITE:  d = wdata;
        OP_SET:    d = q_r | wdata;
        OP_CLEAR:  d = q_r & ~wdata;
        OP_TOGGLE: d = q_r ^ wdata;
        default:   d = q_r;
      endcase
    end
    d = d | force_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/pei_glitch_filter.sv
module pei_glitch_filter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] prev_q, out_q, out_d, agree;

  // Output moves only when the current and previous samples agree;
  // a disabled bit simply follows its input so re-enabling is seamless.
  always_comb begin
    agree = ~(din ^ prev_q);
    out_d = (~en & din) | (en & ((agree & din) | (~agree & out_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
    end else begin
      prev_q <= din;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/pei_edge_detect.sv
module pei_edge_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] mode_lo,
  input  logic [W-1:0] mode_hi,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q, rise, fall, only_rise, only_fall;

  always_comb begin
    rise      = sig & ~prev_q;
    fall      = ~sig & prev_q;
    only_rise = ~mode_hi & mode_lo;
    only_fall = mode_hi & ~mode_lo;
    evt = (only_rise & rise) | (only_fall & fall) |
          (~(only_rise | only_fall) & (rise | fall));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pei_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      pin_in,
  input  logic                  bus_wen,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]      bus_wdata,
  output logic [NPINS-1:0]      bus_rdata,
  output logic                  irq_req,
  output logic [NPINS-1:0]      evt_pulse
);
  logic [REG_IDX_W-1:0] idx;
  alias_op_e            op;
  assign idx = bus_addr[BUS_ADDR_W-1:2];
  assign op  = alias_op_e'(bus_addr[1:0]);

  logic [NPINS-1:0] filt_q, mlo_q, mhi_q, evsel_q;
  logic [NPINS-1:0] ien_q, ien_d, ien_rise;
  logic [NPINS-1:0] flag_q, flag_d, flag_clr;
  logic [NPINS-1:0] pin_s, pin_f, irq_src, evt_src, irq_evt;

  // interrupt enable: next-state, rise detection feeds the filter enable
  always_comb begin
    ien_d = ien_q;
    if (bus_wen && idx == REG_IEN) begin
      unique case (op)
        OP_WRITE:  ien_d = bus_wdata;
        OP_SET:    ien_d = ien_q | bus_wdata;
        OP_CLEAR:  ien_d = ien_q & ~bus_wdata;
        OP_TOGGLE: ien_d = ien_q ^ bus_wdata;
        default:   ien_d = ien_q;
      endcase
    end
    ien_rise = ien_d & ~ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  pei_alias_reg #(.W(NPINS)) u_filt (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && idx == REG_FILT), .op(op),
    .wdata(bus_wdata), .force_set(ien_rise), .q(filt_q));
  pei_alias_reg #(.W(NPINS)) u_mlo (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && idx == REG_MLO), .op(op),
    .wdata(bus_wdata), .force_set('0), .q(mlo_q));
  pei_alias_reg #(.W(NPINS)) u_mhi (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && idx == REG_MHI), .op(op),
    .wdata(bus_wdata), .force_set('0), .q(mhi_q));
  pei_alias_reg #(.W(NPINS)) u_evsel (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && idx == REG_EVSEL), .op(op),
    .wdata(bus_wdata), .force_set('0), .q(evsel_q));

  // input path
  pei_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_s));

  pei_glitch_filter #(.W(NPINS)) u_filter (
    .clk(clk), .rst_n(rst_n), .en(filt_q | evsel_q), .din(pin_s), .dout(pin_f));

  assign irq_src = (filt_q & pin_f) | (~filt_q & pin_s);
  assign evt_src = (evsel_q & pin_f) | (~evsel_q & pin_s);

  pei_edge_detect #(.W(NPINS)) u_irq_det (
    .clk(clk), .rst_n(rst_n), .sig(irq_src), .mode_lo(mlo_q), .mode_hi(mhi_q),
    .evt(irq_evt));
  pei_edge_detect #(.W(NPINS)) u_evt_det (
    .clk(clk), .rst_n(rst_n), .sig(evt_src), .mode_lo(mlo_q), .mode_hi(mhi_q),
    .evt(evt_pulse));

  // sticky flags: a new edge beats a simultaneous clear
  always_comb begin
    flag_clr = (bus_wen && idx == REG_FLAG && op == OP_CLEAR) ? bus_wdata : '0;
    flag_d   = (flag_q & ~flag_clr) | irq_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign irq_req = |(flag_q & ien_q);

  always_comb begin
    unique case (idx)
      REG_FILT:  bus_rdata = filt_q;
      REG_MLO:   bus_rdata = mlo_q;
      REG_MHI:   bus_rdata = mhi_q;
      REG_IEN:   bus_rdata = ien_q;
      REG_EVSEL: bus_rdata = evsel_q;
      REG_FLAG:  bus_rdata = flag_q;
      REG_LEVEL: bus_rdata = pin_s;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk
  import pei_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wen,
  input logic [BUS_ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]      flags,
  input logic [NPINS-1:0]      ien,
  input logic [NPINS-1:0]      gfen,
  input logic                  irq_req
);
  logic clr_wr;
  assign clr_wr = bus_wen && (bus_addr == {REG_FLAG, OP_CLEAR});

  // R4: a flag only drops after a clear-operation write to the flag register
  assert_flag_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags) != '0) |-> $past(clr_wr));

  // R6: request implies some enabled flag
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((flags & ien) != '0));

  // R6: enabled flag implies request
  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien) != '0) |-> irq_req);

  // R7: a newly enabled interrupt has its filter on
  assert_filt_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien & ~$past(ien) & ~gfen) == '0));
endmodule

bind pin_event_irq pin_event_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .flags(flag_q), .ien(ien_q), .gfen(filt_q), .irq_req(irq_req));

// File: tb/pin_event_irq_test.sv
module pin_event_irq_test;
  import pei_pkg::*;

  localparam int unsigned N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_in = '0;
  logic          bus_wen = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          irq_req;
  logic [N-1:0]  evt_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_event_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .evt_pulse(evt_pulse));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input alias_op_e op, input logic [N-1:0] d);
    bus_addr  = {idx, op};
    bus_wdata = d;
    bus_wen   = 1'b1;
    @(negedge clk);
    bus_wen   = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [N-1:0] d);
    bus_addr = {idx, 2'b00};
    #1;
    d = bus_rdata;
  endtask

  task automatic clear_flags();
    wr(REG_FLAG, OP_CLEAR, '1);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), v);
      check("R1 register reset", v, '0);
    end
    check("R1 irq reset", {31'b0, irq_req}, '0);
    check("R1 evt reset", evt_pulse, '0);
  endtask

  task automatic t_alias();
    logic [N-1:0] v;
    wr(REG_MLO, OP_WRITE, 32'hF0F0);
    wr(REG_MLO, OP_SET, 32'h000F);
    rd(REG_MLO, v); check("R2 set op", v, 32'hF0FF);
    wr(REG_MLO, OP_CLEAR, 32'h00F0);
    rd(REG_MLO, v); check("R2 clear op", v, 32'hF00F);
    wr(REG_MLO, OP_TOGGLE, 32'hFF00);
    rd(REG_MLO, v); check("R2 toggle op", v, 32'h0F0F);
    bus_addr = {REG_MLO, OP_TOGGLE}; #1;
    check("R2 read ignores op bits", bus_rdata, 32'h0F0F);
    wr(REG_MLO, OP_WRITE, '0);
    wr(REG_LEVEL, OP_WRITE, '1);
    rd(REG_LEVEL, v); check("R2 level read-only", v, '0);
  endtask

  task automatic t_modes();
    logic [N-1:0] v;
    wr(REG_MLO, OP_SET, 32'b1010);
    wr(REG_MHI, OP_SET, 32'b1100);
    pin_in[3:0] = 4'hF;
    cycles(6);
    rd(REG_FLAG, v); check("R3 rising modes", v & 32'hF, 32'b1011);
    clear_flags();
    pin_in[3:0] = 4'h0;
    cycles(6);
    rd(REG_FLAG, v); check("R3 falling modes", v & 32'hF, 32'b1101);
    clear_flags();
  endtask

  task automatic t_latency();
    logic [N-1:0] v;
    wr(REG_FILT, OP_SET, 32'h1 << 5);
    pin_in[4] = 1'b1;
    cycles(2); rd(REG_FLAG, v); check("R9 unfiltered early", v[4], 1'b0);
    cycles(1); rd(REG_FLAG, v); check("R9 unfiltered on time", v[4], 1'b1);
    pin_in[5] = 1'b1;
    cycles(4); rd(REG_FLAG, v); check("R9 filtered early", v[5], 1'b0);
    cycles(1); rd(REG_FLAG, v); check("R9 filtered on time", v[5], 1'b1);
    clear_flags();
  endtask

  task automatic t_glitch();
    logic [N-1:0] v;
    wr(REG_FILT, OP_SET, 32'h1 << 6);
    cycles(2);
    pin_in[6] = 1'b1; cycles(1); pin_in[6] = 1'b0;
    cycles(8); rd(REG_FLAG, v); check("R8 one-cycle pulse rejected", v[6], 1'b0);
    pin_in[6] = 1'b1; cycles(2); pin_in[6] = 1'b0;
    cycles(8); rd(REG_FLAG, v); check("R8 two-cycle pulse accepted", v[6], 1'b1);
    pin_in[7] = 1'b1; cycles(1); pin_in[7] = 1'b0;
    cycles(8); rd(REG_FLAG, v); check("R8 unfiltered short pulse seen", v[7], 1'b1);
  endtask

  task automatic t_flag_clear();
    logic [N-1:0] v;
    wr(REG_FLAG, OP_WRITE, '0);
    rd(REG_FLAG, v); check("R4 write op ignored", v[6], 1'b1);
    wr(REG_FLAG, OP_TOGGLE, 32'h1 << 6);
    rd(REG_FLAG, v); check("R4 toggle op ignored", v[6], 1'b1);
    wr(REG_FLAG, OP_SET, 32'h1 << 8);
    rd(REG_FLAG, v); check("R4 set op ignored", v[8], 1'b0);
    wr(REG_IEN, OP_SET, 32'h1 << 6);
    check("R6 irq with enabled flag", {31'b0, irq_req}, 32'h1);
    wr(REG_FLAG, OP_CLEAR, 32'h1 << 6);
    rd(REG_FLAG, v); check("R4 clear while enabled", v[6], 1'b0);
    check("R6 irq drops after clear", {31'b0, irq_req}, '0);
    clear_flags();
  endtask

  task automatic t_irq();
    logic [N-1:0] v;
    wr(REG_IEN, OP_WRITE, '0);
    wr(REG_IEN, OP_SET, 32'h1 << 8);
    pin_in[9] = 1'b1;
    cycles(8); rd(REG_FLAG, v);
    check("R6 flag set without enable", v[9], 1'b1);
    check("R6 no irq from masked flag", {31'b0, irq_req}, '0);
    pin_in[8] = 1'b1;
    cycles(8);
    check("R6 irq from enabled flag", {31'b0, irq_req}, 32'h1);
    wr(REG_FLAG, OP_CLEAR, 32'h1 << 8);
    check("R6 irq after clear", {31'b0, irq_req}, '0);
    clear_flags();
  endtask

  task automatic t_ien_filter();
    logic [N-1:0] v;
    wr(REG_FILT, OP_CLEAR, 32'h3 << 10);
    wr(REG_IEN, OP_SET, 32'h1 << 10);
    rd(REG_FILT, v); check("R7 set op enables filter", v[10], 1'b1);
    wr(REG_IEN, OP_TOGGLE, 32'h1 << 11);
    rd(REG_FILT, v); check("R7 toggle op enables filter", v[11], 1'b1);
    wr(REG_FILT, OP_CLEAR, 32'h1 << 10);
    rd(REG_FILT, v); check("R7 filter clearable", v[10], 1'b0);
    rd(REG_IEN, v);  check("R7 enable kept", v[10], 1'b1);
  endtask

  task automatic t_concurrent();
    logic [N-1:0] v;
    pin_in[12] = 1'b1;
    cycles(4); rd(REG_FLAG, v); check("R5 flag prepared", v[12], 1'b1);
    pin_in[12] = 1'b0;
    cycles(2);
    wr(REG_FLAG, OP_CLEAR, 32'h1 << 12);
    rd(REG_FLAG, v); check("R5 edge beats clear", v[12], 1'b1);
    wr(REG_FLAG, OP_CLEAR, 32'h1 << 12);
    rd(REG_FLAG, v); check("R5 later clear works", v[12], 1'b0);
  endtask

  task automatic t_evt();
    pin_in[13] = 1'b1;
    cycles(1); check("R10 unfiltered evt early", evt_pulse[13], 1'b0);
    cycles(1); check("R10 unfiltered evt", evt_pulse[13], 1'b1);
    cycles(1); check("R10 evt one cycle", evt_pulse[13], 1'b0);
    wr(REG_EVSEL, OP_SET, 32'h1 << 13);
    cycles(2);
    pin_in[13] = 1'b0;
    cycles(3); check("R10 filtered evt early", evt_pulse[13], 1'b0);
    cycles(1); check("R10 filtered evt", evt_pulse[13], 1'b1);
    cycles(1); check("R10 filtered evt one cycle", evt_pulse[13], 1'b0);
    clear_flags();
  endtask

  task automatic t_filter_switch();
    logic [N-1:0] v;
    pin_in[14] = 1'b1;
    cycles(4);
    clear_flags();
    wr(REG_FILT, OP_SET, 32'h1 << 14);
    cycles(6); rd(REG_FLAG, v); check("R11 no edge on filter on", v[14], 1'b0);
    wr(REG_FILT, OP_CLEAR, 32'h1 << 14);
    cycles(6); rd(REG_FLAG, v); check("R11 no edge on filter off", v[14], 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_alias();
    t_modes();
    t_latency();
    t_glitch();
    t_flag_clear();
    t_irq();
    t_ien_filter();
    t_concurrent();
    t_evt();
    t_filter_switch();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule